// File: doc/BRIEF.md
# Circular Operand Stack Cache with Background Dribbler

This block keeps the topmost part of a processor operand stack on chip, in a 64-entry ring of 32-bit words. The core pushes, pops, replaces the top word, and reads any cached word by its depth below the top, all in the same cycle. A ring store with a moving oldest slot and an occupancy count takes the place of a conventional register file. No data is copied when the stack grows or shrinks.

A dribbler runs in the background. When occupancy climbs past a high watermark, it writes the oldest cached words out to a word-wide memory port. When occupancy falls under a low watermark and older words are held in memory, it reads them back beneath the cached ones. Hysteresis on both watermarks keeps it from thrashing. The core stalls only when the ring is full on a push, or empty on a pop. Memory holds spilled words at ascending word addresses from zero, with the oldest word lowest.

Top module: `stack_cache`

## Requirements
- R1: After reset the ring is empty: `peek_valid_o` is low for every offset, `mem_req_o` is low, and `ready_o` is high while no operation is requested.
- R2: `peek_data_o` returns the word `peek_off_i` places below the top, where offset 0 is the most recent push. `peek_valid_o` is high exactly when the offset is below the current occupancy.
- R3: An accepted pop removes the top word. Push and pop asserted together replace the top word and leave the occupancy unchanged.
- R4: A pop (or replace) with no cached word, or a push with 64 cached words, drives `ready_o` low. The operation is not performed and the stack contents stay unchanged.
- R5: When occupancy exceeds 48, the dribbler issues a write (`mem_we_o`=1) of the oldest cached word at the current memory pointer. After each write is acknowledged, the memory pointer moves up by one, starting at address 0.
- R6: Once spilling has started, it continues one word per acknowledge until occupancy is 40, and then stops.
- R7: When occupancy is below 8 and memory holds words, the dribbler issues a read (`mem_we_o`=0) at the memory pointer minus one. The returned word becomes the new oldest cached word. Filling continues until occupancy reaches 16 or memory is empty.
- R8: A memory request holds its address, direction and write data stable until `mem_ack_i`. It is withdrawn in the cycle after the acknowledge. Each acknowledge completes exactly one word transfer.
- R9: A core push or replace has priority over a fill for the single write port of the ring. Fill data that arrives during a push is held and written later. The LIFO order of the whole stack, across both the ring and memory, is always preserved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request (with pop_i: replace top) |
| pop_i | input | 1 | Pop request |
| push_data_i | input | 32 | Word to push |
| ready_o | output | 1 | Requested operation is accepted at this clock edge |
| peek_off_i | input | 6 | Depth below top to read |
| peek_data_o | output | 32 | Word at that depth |
| peek_valid_o | output | 1 | Depth lies within the cached words |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 = spill write, 0 = fill read |
| mem_addr_o | output | 16 | Word address in memory |
| mem_wdata_o | output | 32 | Spilled word |
| mem_ack_i | input | 1 | Transfer completed this cycle |
| mem_rdata_i | input | 32 | Filled word, valid with mem_ack_i |

## Verification
Some faults show on the very next sample. A wrong top or oldest pointer, or a wrong occupancy count, moves the `peek_valid_o` boundary or returns a wrong peek word. Faults in the dribbler thresholds or its pointer are seen a few dozen cycles later, as a wrong number of memory transfers or wrong addresses once activity settles. A fill word written to the wrong slot, or lost under a push, may stay hidden for many cycles. It only shows up when the stack is drained, as a break in the popped sequence. For that reason every scenario ends by popping the whole stack and comparing it with a reference.

// File: rtl/stkc_pkg.sv
package stkc_pkg;
    typedef enum logic [1:0] {
        DR_IDLE  = 2'd0,
        DR_SPILL = 2'd1,
        DR_FILL  = 2'd2
    } drib_mode_e;
endpackage

// File: rtl/stkc_store.sv
// Ring storage: one write port, two combinational read ports.
module stkc_store #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PTR_W-1:0] raddr_a,
    output logic [WIDTH-1:0] rdata_a,
    input  logic [PTR_W-1:0] raddr_b,
    output logic [WIDTH-1:0] rdata_b
);
    logic [WIDTH-1:0] ring_d [DEPTH];
    logic [WIDTH-1:0] ring_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ring_d[i] = ring_q[i];
        end
        if (we) begin
            ring_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            ring_q[i] <= ring_d[i];
        end
    end

    assign rdata_a = ring_q[raddr_a];
    assign rdata_b = ring_q[raddr_b];
endmodule

// File: rtl/stkc_dribbler.sv
// Background spill/fill engine with watermark hysteresis.
module stkc_dribbler
    import stkc_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int DEPTH    = 64,
    parameter int MEM_AW   = 16,
    parameter int SPILL_HI = 48,
    parameter int SPILL_LO = 40,
    parameter int FILL_LO  = 8,
    parameter int FILL_HI  = 16,
    localparam int CNT_W   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  occ_i,
    input  logic [WIDTH-1:0]  oldest_i,
    input  logic              core_wr_i,
    output logic              spill_done_o,
    output logic              fill_wr_o,
    output logic [WIDTH-1:0]  fill_data_o,
    output logic              spill_busy_o,
    output logic              fill_busy_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic [WIDTH-1:0]  mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [WIDTH-1:0]  mem_rdata_i
);
    localparam logic [CNT_W-1:0] SPILL_HI_C = CNT_W'(SPILL_HI);
    localparam logic [CNT_W-1:0] SPILL_LO_C = CNT_W'(SPILL_LO);
    localparam logic [CNT_W-1:0] FILL_LO_C  = CNT_W'(FILL_LO);
    localparam logic [CNT_W-1:0] FILL_HI_C  = CNT_W'(FILL_HI);

    typedef struct packed {
        drib_mode_e        mode;
        logic              req;
        logic              we;
        logic [MEM_AW-1:0] ptr;
        logic              fpend;
        logic [WIDTH-1:0]  fdata;
    } drib_st_t;

    drib_st_t st_d, st_q;
    logic     spill_done, fill_wr;

    always_comb begin
        st_d       = st_q;
        spill_done = 1'b0;
        fill_wr    = 1'b0;

        // completion of the outstanding transfer
        if (st_q.req && mem_ack_i) begin
            st_d.req = 1'b0;
            if (st_q.we) begin
                st_d.ptr   = st_q.ptr + MEM_AW'(1);
                spill_done = 1'b1;
            end else begin
                st_d.ptr   = st_q.ptr - MEM_AW'(1);
                st_d.fpend = 1'b1;
                st_d.fdata = mem_rdata_i;
            end
        end

        // held fill word waits for a free ring write port
        if (st_q.fpend && !core_wr_i) begin
            fill_wr    = 1'b1;
            st_d.fpend = 1'b0;
        end

        // issue decision only when nothing is in flight
        if (!st_q.req && !st_q.fpend) begin
            if ((occ_i > SPILL_HI_C) ||
                (st_q.mode == DR_SPILL && occ_i > SPILL_LO_C)) begin
                st_d.mode = DR_SPILL;
                st_d.req  = 1'b1;
                st_d.we   = 1'b1;
            end else if ((st_q.ptr != '0) &&
                         ((occ_i < FILL_LO_C) ||
                          (st_q.mode == DR_FILL && occ_i < FILL_HI_C))) begin
                st_d.mode = DR_FILL;
                st_d.req  = 1'b1;
                st_d.we   = 1'b0;
            end else begin
                st_d.mode = DR_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: DR_IDLE, req: 1'b0, we: 1'b0, ptr: '0,
                      fpend: 1'b0, fdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign spill_done_o = spill_done;
    assign fill_wr_o    = fill_wr;
    assign fill_data_o  = st_q.fdata;
    assign spill_busy_o = st_q.req && st_q.we;
    assign fill_busy_o  = (st_q.req && !st_q.we) || st_q.fpend;
    assign mem_req_o    = st_q.req;
    assign mem_we_o     = st_q.we;
    assign mem_addr_o   = st_q.we ? st_q.ptr : (st_q.ptr - MEM_AW'(1));
    assign mem_wdata_o  = oldest_i;
endmodule

// File: rtl/stack_cache.sv
module stack_cache #(
    parameter int WIDTH    = 32,
    parameter int DEPTH    = 64,
    parameter int MEM_AW   = 16,
    parameter int SPILL_HI = 48,
    parameter int SPILL_LO = 40,
    parameter int FILL_LO  = 8,
    parameter int FILL_HI  = 16,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int CNT_W   = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [WIDTH-1:0]  push_data_i,
    output logic              ready_o,
    input  logic [PTR_W-1:0]  peek_off_i,
    output logic [WIDTH-1:0]  peek_data_o,
    output logic              peek_valid_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic [WIDTH-1:0]  mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [WIDTH-1:0]  mem_rdata_i
);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] oldest;
        logic [CNT_W-1:0] occ;
    } ring_st_t;

    ring_st_t st_d, st_q;

    logic             spill_done, fill_wr, spill_busy, fill_busy;
    logic [WIDTH-1:0] fill_data, oldest_data;
    logic             pop_ok, push_ok, accept, core_wr;
    logic [PTR_W-1:0] top_slot, free_slot, wr_slot, peek_slot;
    logic             st_we;
    logic [PTR_W-1:0] st_waddr;
    logic [WIDTH-1:0] st_wdata;
    logic [CNT_W-1:0] occ_w;

    assign occ_w = st_q.occ;

    always_comb begin
        st_d      = st_q;
        top_slot  = st_q.oldest + st_q.occ[PTR_W-1:0] - PTR_W'(1);
        free_slot = st_q.oldest + st_q.occ[PTR_W-1:0];
        peek_slot = top_slot - peek_off_i;

        // a pop may not remove the word currently being spilled
        pop_ok  = st_q.occ > CNT_W'(spill_busy);
        // a push may not take the slot reserved for a fill in flight
        push_ok = st_q.occ < (FULL_C - CNT_W'(fill_busy));

        if (pop_i)       ready_o = pop_ok;
        else if (push_i) ready_o = push_ok;
        else             ready_o = 1'b1;

        accept  = ready_o && (push_i || pop_i);
        core_wr = accept && push_i;
        wr_slot = pop_i ? top_slot : free_slot;

        // write port: core first, held fill word otherwise
        st_we    = core_wr || fill_wr;
        st_waddr = core_wr ? wr_slot : (st_q.oldest - PTR_W'(1));
        st_wdata = core_wr ? push_data_i : fill_data;

        st_d.occ = st_q.occ
                 + CNT_W'(accept && push_i && !pop_i)
                 - CNT_W'(accept && pop_i && !push_i)
                 + CNT_W'(fill_wr)
                 - CNT_W'(spill_done);
        if (spill_done) st_d.oldest = st_q.oldest + PTR_W'(1);
        if (fill_wr)    st_d.oldest = st_q.oldest - PTR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{oldest: '0, occ: '0};
        else        st_q <= st_d;
    end

    assign peek_valid_o = CNT_W'(peek_off_i) < st_q.occ;

    stkc_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .we      (st_we),
        .waddr   (st_waddr),
        .wdata   (st_wdata),
        .raddr_a (peek_slot),
        .rdata_a (peek_data_o),
        .raddr_b (st_q.oldest),
        .rdata_b (oldest_data)
    );

    stkc_dribbler #(
        .WIDTH(WIDTH), .DEPTH(DEPTH), .MEM_AW(MEM_AW),
        .SPILL_HI(SPILL_HI), .SPILL_LO(SPILL_LO),
        .FILL_LO(FILL_LO), .FILL_HI(FILL_HI)
    ) u_drib (
        .clk          (clk),
        .rst_n        (rst_n),
        .occ_i        (st_q.occ),
        .oldest_i     (oldest_data),
        .core_wr_i    (core_wr),
        .spill_done_o (spill_done),
        .fill_wr_o    (fill_wr),
        .fill_data_o  (fill_data),
        .spill_busy_o (spill_busy),
        .fill_busy_o  (fill_busy),
        .mem_req_o    (mem_req_o),
        .mem_we_o     (mem_we_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_ack_i    (mem_ack_i),
        .mem_rdata_i  (mem_rdata_i)
    );
endmodule

// File: rtl/stack_cache_chk.sv
module stack_cache_chk #(
    parameter int WIDTH    = 32,
    parameter int DEPTH    = 64,
    parameter int MEM_AW   = 16,
    parameter int SPILL_LO = 40,
    parameter int FILL_HI  = 16,
    localparam int CNT_W   = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_i,
    input logic              pop_i,
    input logic              ready_o,
    input logic [CNT_W-1:0]  occ,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [MEM_AW-1:0] mem_addr_o,
    input logic [WIDTH-1:0]  mem_wdata_o,
    input logic              mem_ack_i
);
    // R8: request stays put until acknowledged
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) &&
                                       $stable(mem_addr_o)));
    a_r8_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && !mem_ack_i) |=> $stable(mem_wdata_o));
    // R8: withdrawn after acknowledge
    a_r8_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i) |=> !mem_req_o);
    // R4: empty pop stalls
    a_r4_empty_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && occ == '0) |-> !ready_o);
    // R4: full push stalls
    a_r4_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && occ == CNT_W'(DEPTH)) |-> !ready_o);
    // R4: occupancy never exceeds capacity
    a_r4_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));
    // R6: a spill is only started above the low spill mark
    a_r6_spill_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req_o) && mem_we_o) |-> ($past(occ) > CNT_W'(SPILL_LO)));
    // R7: a fill is only started below the high fill mark
    a_r7_fill_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req_o) && !mem_we_o) |-> ($past(occ) < CNT_W'(FILL_HI)));
endmodule

bind stack_cache stack_cache_chk #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .MEM_AW(MEM_AW),
    .SPILL_LO(SPILL_LO), .FILL_HI(FILL_HI)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .ready_o     (ready_o),
    .occ         (occ_w),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i)
);

// File: tb/stack_cache_tb.sv
`timescale 1ns/1ps
module stack_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0, pop_i = 1'b0;
    logic [31:0] push_data_i = '0;
    logic        ready_o;
    logic [5:0]  peek_off_i = '0;
    logic [31:0] peek_data_o;
    logic        peek_valid_o;
    logic        mem_req_o, mem_we_o;
    logic [15:0] mem_addr_o;
    logic [31:0] mem_wdata_o;
    logic        mem_ack_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;

    always #2.5 clk = ~clk;

    stack_cache u_dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .push_data_i(push_data_i), .ready_o(ready_o),
        .peek_off_i(peek_off_i), .peek_data_o(peek_data_o),
        .peek_valid_o(peek_valid_o), .mem_req_o(mem_req_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // backing memory model
    logic [31:0] mem [256];
    logic        ack_en = 1'b1;
    int wr_cnt = 0, rd_cnt = 0, first_rd = -1, last_rd = -1, max_wr = -1;

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack_i <= 1'b0;
            wr_cnt <= 0; rd_cnt <= 0; first_rd <= -1; last_rd <= -1; max_wr <= -1;
        end else if (mem_ack_i) begin
            mem_ack_i <= 1'b0;
        end else if (mem_req_o && ack_en) begin
            mem_ack_i <= 1'b1;
            if (mem_we_o) begin
                mem[mem_addr_o[7:0]] <= mem_wdata_o;
                wr_cnt <= wr_cnt + 1;
                if (int'(mem_addr_o) > max_wr) max_wr <= int'(mem_addr_o);
            end else begin
                mem_rdata_i <= mem[mem_addr_o[7:0]];
                if (rd_cnt == 0) first_rd <= int'(mem_addr_o);
                last_rd <= int'(mem_addr_o);
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    // reference stack
    logic [31:0] model [256];
    int msp = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; push_i = 0; pop_i = 0; ack_en = 1'b1; msp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one core operation; waits while stalled
    task automatic op(input bit p, input bit q, input logic [31:0] d);
        int guard = 0;
        @(negedge clk);
        push_i = p; pop_i = q; push_data_i = d; #1;
        while (!ready_o && guard < 2000) begin
            @(negedge clk); #1; guard++;
        end
        if (guard >= 2000) check(0, "R4 op timeout", 0, 1);
        if (p && q) model[msp-1] = d;
        else if (p) begin model[msp] = d; msp++; end
        else msp--;
        @(posedge clk); #1;
        push_i = 0; pop_i = 0;
    endtask

    task automatic peek(input int off, output logic v, output logic [31:0] d);
        @(negedge clk);
        peek_off_i = 6'(off); #1;
        v = peek_valid_o; d = peek_data_o;
    endtask

    // pop everything and compare with the reference (R9 order)
    task automatic drain(input string req);
        int bad = 0; logic [31:0] a = 0, e = 0;
        peek_off_i = '0;
        while (msp > 0) begin
            int guard = 0;
            @(negedge clk);
            pop_i = 1; #1;
            while (!ready_o && guard < 2000) begin @(negedge clk); #1; guard++; end
            if (guard >= 2000) begin bad++; pop_i = 0; break; end
            if (peek_data_o !== model[msp-1] && bad == 0) begin
                a = peek_data_o; e = model[msp-1]; bad++;
            end
            msp--;
            @(posedge clk); #1; pop_i = 0;
        end
        check(bad == 0, req, a, e);
    endtask

    task automatic t_reset();
        logic v; logic [31:0] d;
        do_reset();
        peek(0, v, d);
        check(v == 0, "R1 peek invalid", v, 0);
        check(mem_req_o == 0, "R1 no request", mem_req_o, 0);
        check(ready_o == 1, "R1 ready idle", ready_o, 1);
    endtask

    task automatic t_basic();
        logic v; logic [31:0] d;
        do_reset();
        for (int i = 0; i < 5; i++) op(1, 0, 32'hA0 + 32'(i));
        for (int i = 0; i < 5; i++) begin
            peek(i, v, d);
            check(v && d == 32'hA4 - 32'(i), "R2 peek order", d, 32'hA4 - 32'(i));
        end
        peek(5, v, d);
        check(v == 0, "R2 peek bound", v, 0);
        op(0, 1, 0);
        peek(0, v, d);
        check(d == 32'hA3, "R3 pop top", d, 32'hA3);
        op(1, 1, 32'h5EED);
        peek(0, v, d);
        check(d == 32'h5EED, "R3 replace top", d, 32'h5EED);
        peek(4, v, d);
        check(v == 0, "R3 replace keeps occupancy", v, 0);
        peek(3, v, d);
        check(v == 1, "R3 replace keeps occupancy", v, 1);
        drain("R3 drain");
    endtask

    task automatic t_empty();
        logic v; logic [31:0] d;
        do_reset();
        @(negedge clk); pop_i = 1; #1;
        check(ready_o == 0, "R4 empty pop stall", ready_o, 0);
        repeat (3) @(negedge clk);
        #1 check(ready_o == 0, "R4 empty pop held", ready_o, 0);
        push_i = 1; push_data_i = 32'h77; #1;
        check(ready_o == 0, "R4 empty replace stall", ready_o, 0);
        push_i = 0; pop_i = 0;
        peek(0, v, d);
        check(v == 0, "R4 empty unchanged", v, 0);
    endtask

    task automatic t_hyst();
        logic v; logic [31:0] d;
        do_reset();
        for (int i = 0; i < 49; i++) op(1, 0, 32'h1000 + 32'(i));
        repeat (60) @(negedge clk);
        check(wr_cnt == 9, "R6 spill count", wr_cnt, 9);
        check(max_wr == 8, "R5 spill addresses", max_wr, 8);
        check(mem[0] == 32'h1000 && mem[8] == 32'h1008, "R5 oldest spilled first", mem[8], 32'h1008);
        peek(39, v, d);
        check(v && d == 32'h1009, "R6 stop at low mark", d, 32'h1009);
        peek(40, v, d);
        check(v == 0, "R6 stop at low mark", v, 0);
        for (int i = 0; i < 33; i++) op(0, 1, 0);
        repeat (60) @(negedge clk);
        check(rd_cnt == 9, "R7 fill count", rd_cnt, 9);
        check(first_rd == 8 && last_rd == 0, "R7 fill addresses", first_rd, 8);
        check(mem_req_o == 0, "R7 memory empty stops", mem_req_o, 0);
        peek(15, v, d);
        check(v && d == 32'h1000, "R7 refilled oldest", d, 32'h1000);
        peek(16, v, d);
        check(v == 0, "R7 occupancy 16", v, 0);
        drain("R9 drain after round trip");
    endtask

    task automatic t_full();
        do_reset();
        ack_en = 1'b0;
        for (int i = 0; i < 64; i++) op(1, 0, 32'h2000 + 32'(i));
        @(negedge clk); push_i = 1; push_data_i = 32'hDEAD; #1;
        check(ready_o == 0, "R4 full push stall", ready_o, 0);
        repeat (5) @(negedge clk);
        #1 check(ready_o == 0, "R4 full push held", ready_o, 0);
        push_i = 0;
        check(mem_req_o && mem_we_o && mem_addr_o == 0, "R8 request held", mem_addr_o, 0);
        ack_en = 1'b1;
        repeat (120) @(negedge clk);
        check(wr_cnt == 24, "R8 one word per ack", wr_cnt, 24);
        drain("R4 full drain");
    endtask

    task automatic t_prio();
        do_reset();
        for (int i = 0; i < 49; i++) op(1, 0, 32'h3000 + 32'(i));
        repeat (60) @(negedge clk);
        ack_en = 1'b0;
        for (int i = 0; i < 33; i++) op(0, 1, 0);
        repeat (3) @(negedge clk);
        ack_en = 1'b1;
        for (int i = 0; i < 12; i++) op(1, 0, 32'h4000 + 32'(i));
        repeat (60) @(negedge clk);
        drain("R9 fill under pushes");
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_empty();
        t_hyst();
        t_full();
        t_prio();
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            summary();
            $finish;
        end
    end
endmodule